// File: doc/BRIEF.md
# I2C Bit-Timing Generator

This block times the individual bus phases of an I2C master. A protocol sequencer asks for one phase at a time: START setup, START hold, STOP setup, data setup, data hold, SCL low, SCL high or repeated-START release. The block counts out that phase's duration in input clocks and pulses a strobe in the last cycle. Each duration is an 8-bit per-phase count scaled by a shared 8-bit prescaler. The SCL-high phase is also stretched by a fixed overhead plus a term for the input glitch-filter delay, so one low phase and one high phase together make up the full SCL period.

Two timing register sets are provided: one for fast speed and one for high speed. A mode bit in the configuration word picks the set. The data-hold count lives in its own word and is shared by both modes. The block also reports, combinationally, the SCL period the selected set produces and whether that set is legal. Any new values the sequencer or software write take effect only when the next phase is accepted.

Top module: `i2c_tgen`

## Requirements
- R1: After reset, `req_ready` is 1 and both `phase_done` and `phase_strb` are 0.
- R2: Phase codes are 0 START setup, 1 START hold, 2 STOP setup, 3 data setup, 4 data hold, 5 SCL low, 6 SCL high and 7 repeated-START release. Every phase except SCL high lasts (F+1)·(D+1) clocks. F is the phase's field and D is the prescaler field.
- R3: The SCL-high phase lasts (F+1)·(D+1) + 8 + 2·G clocks, where G is the filter count in configuration bits [18:16].
- R4: The phase length counts clocks from the accepting edge through the cycle in which `phase_done` is 1. In that same cycle, `phase_strb` has exactly bit <code> set. `req_ready` is 0 while a phase runs and is 1 again in the cycle after `phase_done`.
- R5: When configuration bit 29 is 1, the high-speed words supply every field. When it is 0, the fast-speed words supply them.
- R6: `scl_period` equals (D+1)·(L+H+2) + 8 + 2·G for the selected set, where L and H are the SCL-low and SCL-high fields.
- R7: `cfg_ok` is 1 exactly when 2 ≤ L+H ≤ 510 and (D+1)·(L+H+2) ≥ 4.
- R8: Word 1 holds START setup in [31:24], START hold in [23:16] and STOP setup in [15:8]. Word 2 holds data setup in [31:24], SCL low in [15:8] and SCL high in [7:0]. Word 3 holds D in [23:16] and repeated-START release in [7:0]. A change to any word while a phase runs leaves that phase's length unchanged and applies from the next accepted phase.
- R9: A request raised while a phase runs is ignored. Only the running phase's strobe appears, and no further phase starts once the request is withdrawn.
- R10: The data-hold phase takes its field from bits [7:0] of the separate hold word, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conf_word | input | 32 | Configuration: filter count [18:16], high-speed select bit 29 |
| fs_word1 | input | 32 | Fast-speed START/STOP timing word |
| fs_word2 | input | 32 | Fast-speed data setup and SCL low/high word |
| fs_word3 | input | 32 | Fast-speed prescaler and repeated-START release word |
| hs_word1 | input | 32 | High-speed START/STOP timing word |
| hs_word2 | input | 32 | High-speed data setup and SCL low/high word |
| hs_word3 | input | 32 | High-speed prescaler and repeated-START release word |
| hold_word | input | 32 | Data-hold count in [7:0], shared by both modes |
| req_valid | input | 1 | Phase request from the sequencer |
| req_phase | input | 3 | Code of the requested phase |
| req_ready | output | 1 | Block idle; a request is accepted on this edge |
| phase_done | output | 1 | High in the last cycle of the running phase |
| phase_strb | output | 8 | One-hot end-of-phase strobe indexed by phase code |
| scl_period | output | 18 | SCL period in clocks for the selected set |
| cfg_ok | output | 1 | Selected set satisfies the legality limits |

## Verification
The main sweep covers all eight phase codes under four prescaler values, four field patterns and several filter counts, in both modes. Each phase gets a different field value, so a wrong field pick shows up as a wrong length. A shifted prescaler or missing overhead shows up as an off-by-(D+1) or off-by-constant error. The inactive register set always holds decoy values with a different prescaler, which separates a correct mode select from a swapped one. Directed cases rewrite the words in mid-phase and raise a request while busy, to show that a running phase is neither stretched nor pre-empted. Extreme and near-zero SCL fields exercise the period arithmetic and the legality flag.

// File: rtl/i2c_tgen_pkg.sv
`timescale 1ns/1ps
package i2c_tgen_pkg;

   localparam int WORD_W  = 32;
   localparam int FIELD_W = 8;
   localparam int DIV_W   = 8;
   localparam int FLT_W   = 3;
   localparam int PH_W    = 3;
   localparam int NUM_PH  = 1 << PH_W;

   // Field positions inside the timing words (decoded by software and here)
   localparam int W1_STA_SU_LSB = 24;
   localparam int W1_STA_HD_LSB = 16;
   localparam int W1_STO_SU_LSB = 8;
   localparam int W2_DAT_SU_LSB = 24;
   localparam int W2_LOW_LSB    = 8;
   localparam int W2_HIGH_LSB   = 0;
   localparam int W3_DIV_LSB    = 16;
   localparam int W3_SR_LSB     = 0;
   localparam int HOLD_LSB      = 0;
   localparam int CONF_FLT_LSB  = 16;
   localparam int CONF_HS_BIT   = 29;

   // Legality limits on the SCL fields
   localparam int MIN_SUM    = 2;
   localparam int MAX_SUM    = 510;
   localparam int MIN_SCALED = 4;

   typedef enum logic [PH_W-1:0] {
      PH_STA_SU = 3'd0,
      PH_STA_HD = 3'd1,
      PH_STO_SU = 3'd2,
      PH_DAT_SU = 3'd3,
      PH_DAT_HD = 3'd4,
      PH_SCL_LO = 3'd5,
      PH_SCL_HI = 3'd6,
      PH_SR_REL = 3'd7
   } phase_e;

   typedef struct packed {
      logic [DIV_W-1:0]   div;
      logic [FIELD_W-1:0] sta_su;
      logic [FIELD_W-1:0] sta_hd;
      logic [FIELD_W-1:0] sto_su;
      logic [FIELD_W-1:0] dat_su;
      logic [FIELD_W-1:0] scl_lo;
      logic [FIELD_W-1:0] scl_hi;
      logic [FIELD_W-1:0] sr_rel;
   } tset_t;

   function automatic tset_t decode_set(input logic [WORD_W-1:0] w1,
                                        input logic [WORD_W-1:0] w2,
                                        input logic [WORD_W-1:0] w3);
      tset_t s;
      s.sta_su = w1[W1_STA_SU_LSB +: FIELD_W];
      s.sta_hd = w1[W1_STA_HD_LSB +: FIELD_W];
      s.sto_su = w1[W1_STO_SU_LSB +: FIELD_W];
      s.dat_su = w2[W2_DAT_SU_LSB +: FIELD_W];
      s.scl_lo = w2[W2_LOW_LSB    +: FIELD_W];
      s.scl_hi = w2[W2_HIGH_LSB   +: FIELD_W];
      s.div    = w3[W3_DIV_LSB    +: DIV_W];
      s.sr_rel = w3[W3_SR_LSB     +: FIELD_W];
      return s;
   endfunction

endpackage

// File: rtl/i2c_tgen_regsel.sv
`timescale 1ns/1ps
module i2c_tgen_regsel
   import i2c_tgen_pkg::*;
#(
   parameter int HS_ENABLE = 1
) (
   input  logic [WORD_W-1:0]  conf_word,
   input  logic [WORD_W-1:0]  fs_word1,
   input  logic [WORD_W-1:0]  fs_word2,
   input  logic [WORD_W-1:0]  fs_word3,
   input  logic [WORD_W-1:0]  hs_word1,
   input  logic [WORD_W-1:0]  hs_word2,
   input  logic [WORD_W-1:0]  hs_word3,
   input  logic [WORD_W-1:0]  hold_word,
   output tset_t              act_set,
   output logic [FIELD_W-1:0] hold_cnt,
   output logic [FLT_W-1:0]   flt_cnt
);

   tset_t fs_set;
   tset_t hs_set;
   logic  unused_word_bits;

   assign fs_set   = decode_set(fs_word1, fs_word2, fs_word3);
   assign hs_set   = decode_set(hs_word1, hs_word2, hs_word3);
   assign hold_cnt = hold_word[HOLD_LSB +: FIELD_W];
   assign flt_cnt  = conf_word[CONF_FLT_LSB +: FLT_W];

   generate
      if (HS_ENABLE != 0) begin : g_dual
         assign act_set = conf_word[CONF_HS_BIT] ? hs_set : fs_set;
      end else begin : g_fs_only
         assign act_set = fs_set;
      end
   endgenerate

   // Bits outside the decoded fields are reserved
   assign unused_word_bits = ^{conf_word, fs_word1, fs_word2, fs_word3,
                               hs_word1, hs_word2, hs_word3, hold_word,
                               hs_set, fs_set};

endmodule

// File: rtl/i2c_tgen_period.sv
`timescale 1ns/1ps
module i2c_tgen_period
   import i2c_tgen_pkg::*;
#(
   parameter int OVERHEAD_CLKS = 8,
   parameter int FLT_MULT      = 2,
   parameter int PERIOD_W      = DIV_W + FIELD_W + 2
) (
   input  tset_t               act_set,
   input  logic [FLT_W-1:0]    flt_cnt,
   output logic [PERIOD_W-1:0] scl_period,
   output logic                cfg_ok
);

   localparam int SUM_W = FIELD_W + 1;

   logic [SUM_W-1:0]    lh_sum;
   logic [PERIOD_W-1:0] scaled;
   logic [PERIOD_W-1:0] filt_term;

   assign lh_sum    = SUM_W'(act_set.scl_lo) + SUM_W'(act_set.scl_hi);
   assign scaled    = (PERIOD_W'(act_set.div) + PERIOD_W'(1)) *
                      (PERIOD_W'(lh_sum) + PERIOD_W'(2));
   assign filt_term = PERIOD_W'(FLT_MULT) * PERIOD_W'(flt_cnt);

   assign scl_period = scaled + PERIOD_W'(OVERHEAD_CLKS) + filt_term;

   assign cfg_ok = (lh_sum >= SUM_W'(MIN_SUM)) &&
                   (lh_sum <= SUM_W'(MAX_SUM)) &&
                   (scaled >= PERIOD_W'(MIN_SCALED));

endmodule

// File: rtl/i2c_tgen_prescale.sv
`timescale 1ns/1ps
module i2c_tgen_prescale #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= tick ? '0 : cnt + CNT_W'(1);
      end
   end

   // R2
   pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= limit));

endmodule

// File: rtl/i2c_tgen_phase_ctr.sv
`timescale 1ns/1ps
module i2c_tgen_phase_ctr #(
   parameter int CNT_W = 8,
   parameter int EXT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic [EXT_W-1:0] ext_in,
   input  logic             tick,
   output logic             busy,
   output logic             run,
   output logic             finish
);

   logic             in_ext;
   logic [CNT_W-1:0] rem;
   logic [EXT_W-1:0] ext;
   logic             last_tick;

   assign run       = busy && !in_ext;
   assign last_tick = run && tick && (rem == '0);
   assign finish    = (last_tick && (ext == '0)) ||
                      (busy && in_ext && (ext == EXT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         in_ext <= 1'b0;
         rem    <= '0;
         ext    <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         in_ext <= 1'b0;
         rem    <= cnt_in;
         ext    <= ext_in;
      end else if (finish) begin
         busy   <= 1'b0;
         in_ext <= 1'b0;
      end else if (last_tick) begin
         in_ext <= 1'b1;
      end else if (in_ext) begin
         ext <= ext - EXT_W'(1);
      end else if (run && tick) begin
         rem <= rem - CNT_W'(1);
      end
   end

   // R3
   ext_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ext |-> (busy && (ext != '0)));

   // R2
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/i2c_tgen.sv
`timescale 1ns/1ps
module i2c_tgen
   import i2c_tgen_pkg::*;
#(
   parameter int HS_ENABLE     = 1,
   parameter int OVERHEAD_CLKS = 8,
   parameter int FLT_MULT      = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [31:0]                   conf_word,
   input  logic [31:0]                   fs_word1,
   input  logic [31:0]                   fs_word2,
   input  logic [31:0]                   fs_word3,
   input  logic [31:0]                   hs_word1,
   input  logic [31:0]                   hs_word2,
   input  logic [31:0]                   hs_word3,
   input  logic [31:0]                   hold_word,
   input  logic                          req_valid,
   input  logic [2:0]                    req_phase,
   output logic                          req_ready,
   output logic                          phase_done,
   output logic [7:0]                    phase_strb,
   output logic [17:0]                   scl_period,
   output logic                          cfg_ok
);

   localparam int EXT_MAX    = OVERHEAD_CLKS + FLT_MULT * ((1 << FLT_W) - 1);
   localparam int EXT_W      = (EXT_MAX < 1) ? 1 : $clog2(EXT_MAX + 1);
   localparam int PERIOD_W   = DIV_W + FIELD_W + 2;
   localparam longint MAX_PERIOD = longint'(1 << DIV_W) *
                                   longint'(2 * ((1 << FIELD_W) - 1) + 2) +
                                   longint'(EXT_MAX);

   // Elaboration-time parameter checks
   generate
      if (HS_ENABLE != 0 && HS_ENABLE != 1) begin : g_bad_hs
         $error("HS_ENABLE must be 0 or 1");
      end
      if (OVERHEAD_CLKS < 0 || FLT_MULT < 0) begin : g_bad_ovh
         $error("overhead terms must be non-negative");
      end
      if (MAX_PERIOD >= (longint'(1) << PERIOD_W)) begin : g_bad_pw
         $error("period does not fit in the period output");
      end
      if (PERIOD_W != 18 || NUM_PH != 8 || WORD_W != 32) begin : g_bad_port
         $error("port widths disagree with the package");
      end
   endgenerate

   tset_t               act_set;
   logic [FIELD_W-1:0]  hold_cnt;
   logic [FLT_W-1:0]    flt_cnt;
   phase_e              req_ph;
   phase_e              cur_phase;
   logic [FIELD_W-1:0]  sel_cnt;
   logic [EXT_W-1:0]    sel_ext;
   logic [DIV_W-1:0]    snap_div;
   logic                accept;
   logic                busy;
   logic                run;
   logic                tick;
   logic                finish;

   i2c_tgen_regsel #(.HS_ENABLE(HS_ENABLE)) u_regsel (
      .conf_word (conf_word),
      .fs_word1  (fs_word1),
      .fs_word2  (fs_word2),
      .fs_word3  (fs_word3),
      .hs_word1  (hs_word1),
      .hs_word2  (hs_word2),
      .hs_word3  (hs_word3),
      .hold_word (hold_word),
      .act_set   (act_set),
      .hold_cnt  (hold_cnt),
      .flt_cnt   (flt_cnt)
   );

   i2c_tgen_period #(
      .OVERHEAD_CLKS (OVERHEAD_CLKS),
      .FLT_MULT      (FLT_MULT),
      .PERIOD_W      (PERIOD_W)
   ) u_period (
      .act_set    (act_set),
      .flt_cnt    (flt_cnt),
      .scl_period (scl_period),
      .cfg_ok     (cfg_ok)
   );

   assign req_ph    = phase_e'(req_phase);
   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   // Field pick for the requested phase
   always_comb begin
      sel_ext = '0;
      unique case (req_ph)
         PH_STA_SU: sel_cnt = act_set.sta_su;
         PH_STA_HD: sel_cnt = act_set.sta_hd;
         PH_STO_SU: sel_cnt = act_set.sto_su;
         PH_DAT_SU: sel_cnt = act_set.dat_su;
         PH_DAT_HD: sel_cnt = hold_cnt;
         PH_SCL_LO: sel_cnt = act_set.scl_lo;
         PH_SCL_HI: begin
            sel_cnt = act_set.scl_hi;
            sel_ext = EXT_W'(OVERHEAD_CLKS) + EXT_W'(FLT_MULT) * EXT_W'(flt_cnt);
         end
         PH_SR_REL: sel_cnt = act_set.sr_rel;
         default:   sel_cnt = act_set.sta_su;
      endcase
   end

   // Snapshot taken only when a phase is accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_div  <= '0;
         cur_phase <= PH_STA_SU;
      end else if (accept) begin
         snap_div  <= act_set.div;
         cur_phase <= req_ph;
      end
   end

   i2c_tgen_prescale #(.CNT_W(DIV_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .run   (run),
      .limit (snap_div),
      .tick  (tick)
   );

   i2c_tgen_phase_ctr #(.CNT_W(FIELD_W), .EXT_W(EXT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .cnt_in (sel_cnt),
      .ext_in (sel_ext),
      .tick   (tick),
      .busy   (busy),
      .run    (run),
      .finish (finish)
   );

   assign phase_done = finish;

   generate
      for (genvar gi = 0; gi < NUM_PH; gi++) begin : g_strb
         assign phase_strb[gi] = finish && (cur_phase == phase_e'(gi));
      end
   endgenerate

   // R4
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R4
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_done |=> req_ready);

   // R4
   strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_strb));

   // R8
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(snap_div));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(cur_phase));

endmodule

// File: tb/i2c_tgen_test.sv
`timescale 1ns/1ps
module i2c_tgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] conf_word = '0;
   logic [31:0] fs_word1 = '0, fs_word2 = '0, fs_word3 = '0;
   logic [31:0] hs_word1 = '0, hs_word2 = '0, hs_word3 = '0;
   logic [31:0] hold_word = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_phase = '0;
   logic        req_ready;
   logic        phase_done;
   logic [7:0]  phase_strb;
   logic [17:0] scl_period;
   logic        cfg_ok;

   int total = 0;
   int fails = 0;
   int fv [8];

   always #4 clk = ~clk;

   i2c_tgen uut (
      .clk(clk), .rst_n(rst_n), .conf_word(conf_word),
      .fs_word1(fs_word1), .fs_word2(fs_word2), .fs_word3(fs_word3),
      .hs_word1(hs_word1), .hs_word2(hs_word2), .hs_word3(hs_word3),
      .hold_word(hold_word), .req_valid(req_valid), .req_phase(req_phase),
      .req_ready(req_ready), .phase_done(phase_done), .phase_strb(phase_strb),
      .scl_period(scl_period), .cfg_ok(cfg_ok)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic [31:0] mk_w1(input int a, input int b, input int c);
      return {a[7:0], b[7:0], c[7:0], 8'h00};
   endfunction
   function automatic [31:0] mk_w2(input int dsu, input int lo, input int hi);
      return {dsu[7:0], 8'h00, lo[7:0], hi[7:0]};
   endfunction
   function automatic [31:0] mk_w3(input int dv, input int sr);
      return {8'h00, dv[7:0], 8'h00, sr[7:0]};
   endfunction
   function automatic [31:0] mk_conf(input int hs, input int flt);
      return {2'b00, hs[0], 10'b0, flt[2:0], 16'h0000};
   endfunction

   // Active set gets distinct per-phase fields; the other set holds decoys
   task automatic setup(input int mode, input int dv, input int base, input int flt);
      logic [31:0] a1, a2, a3, d1, d2, d3;
      for (int p = 0; p < 8; p++) fv[p] = (base + p) % 5;
      a1 = mk_w1(fv[0], fv[1], fv[2]);
      a2 = mk_w2(fv[3], fv[5], fv[6]);
      a3 = mk_w3(dv, fv[7]);
      d1 = mk_w1(7, 7, 7);
      d2 = mk_w2(7, 7, 7);
      d3 = mk_w3(4, 7);
      if (mode != 0) begin
         hs_word1 = a1; hs_word2 = a2; hs_word3 = a3;
         fs_word1 = d1; fs_word2 = d2; fs_word3 = d3;
      end else begin
         fs_word1 = a1; fs_word2 = a2; fs_word3 = a3;
         hs_word1 = d1; hs_word2 = d2; hs_word3 = d3;
      end
      hold_word = {24'h0, 8'(fv[4])};
      conf_word = mk_conf(mode, flt);
   endtask

   task automatic run_phase(input int code, input int expn, input string tag);
      int n;
      @(negedge clk);
      req_valid = 1'b1;
      req_phase = code[2:0];
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!phase_done && n < 500) begin
         @(negedge clk);
         n++;
      end
      chk(n == expn, tag, n, expn);
      chk(phase_strb == (8'h01 << code), "R4 strobe", int'(phase_strb), 1 << code);
      @(negedge clk);
      chk(req_ready == 1'b1, "R4 ready", int'(req_ready), 1);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

   initial begin
      int n;
      int expn;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
      chk(phase_done == 1'b0, "R1 done", int'(phase_done), 0);
      chk(phase_strb == 8'h00, "R1 strobe", int'(phase_strb), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep: both modes, prescalers 0..3, four field patterns, all phases
      for (int mode = 0; mode < 2; mode++) begin
         for (int dv = 0; dv < 4; dv++) begin
            for (int base = 0; base < 4; base++) begin
               int flt;
               flt = (base * 3 + dv) % 8;
               setup(mode, dv, base, flt);
               @(negedge clk);
               // R6
               expn = (dv + 1) * (fv[5] + fv[6] + 2) + 8 + 2 * flt;
               chk(int'(scl_period) == expn, "R6 period", int'(scl_period), expn);
               // R7
               chk(cfg_ok == ((fv[5] + fv[6]) >= 2), "R7 legal", int'(cfg_ok),
                   int'((fv[5] + fv[6]) >= 2));
               for (int p = 0; p < 8; p++) begin
                  expn = (fv[p] + 1) * (dv + 1);
                  if (p == 6) begin
                     expn += 8 + 2 * flt;
                     run_phase(p, expn, "R3 scl high");
                  end else if (p == 4) begin
                     run_phase(p, expn, "R10 data hold");
                  end else if (mode != 0) begin
                     run_phase(p, expn, "R5 hs set");
                  end else begin
                     run_phase(p, expn, "R2 fs set");
                  end
               end
            end
         end
      end

      // R7 / R6 extremes
      fs_word2 = mk_w2(0, 0, 0); fs_word3 = mk_w3(0, 0); conf_word = mk_conf(0, 0);
      @(negedge clk);
      chk(cfg_ok == 1'b0, "R7 sum0", int'(cfg_ok), 0);
      fs_word2 = mk_w2(0, 1, 0);
      @(negedge clk);
      chk(cfg_ok == 1'b0, "R7 sum1", int'(cfg_ok), 0);
      fs_word2 = mk_w2(0, 1, 1);
      @(negedge clk);
      chk(cfg_ok == 1'b1, "R7 sum2", int'(cfg_ok), 1);
      fs_word2 = mk_w2(0, 255, 255); fs_word3 = mk_w3(255, 0); conf_word = mk_conf(0, 7);
      @(negedge clk);
      chk(int'(scl_period) == 131094, "R6 max", int'(scl_period), 131094);
      chk(cfg_ok == 1'b1, "R7 max", int'(cfg_ok), 1);

      // R8: rewrite words mid-phase
      conf_word = mk_conf(0, 0);
      fs_word2 = mk_w2(0, 3, 3); fs_word3 = mk_w3(1, 0);
      @(negedge clk);
      req_valid = 1'b1; req_phase = 3'd5;
      @(negedge clk);
      req_valid = 1'b0; n = 1;
      @(negedge clk); n++;
      fs_word2 = mk_w2(0, 0, 3); fs_word3 = mk_w3(3, 0);
      while (!phase_done && n < 500) begin
         @(negedge clk);
         n++;
      end
      chk(n == 8, "R8 no mid-phase effect", n, 8);
      @(negedge clk);
      run_phase(5, 4, "R8 next phase uses new words");

      // R9: request while busy is ignored
      fs_word2 = mk_w2(0, 9, 9); fs_word3 = mk_w3(0, 0); fs_word1 = mk_w1(2, 2, 2);
      @(negedge clk);
      req_valid = 1'b1; req_phase = 3'd5;
      @(negedge clk);
      req_valid = 1'b0; n = 1;
      @(negedge clk); n++;
      req_valid = 1'b1; req_phase = 3'd0;
      @(negedge clk); n++;
      req_valid = 1'b0;
      while (!phase_done && n < 500) begin
         @(negedge clk);
         n++;
      end
      chk(n == 10, "R9 length kept", n, 10);
      chk(phase_strb == 8'h20, "R9 strobe", int'(phase_strb), 32);
      begin
         int extra;
         extra = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (phase_done || !req_ready) extra++;
         end
         chk(extra == 0, "R9 no late phase", extra, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

endmodule